// File: doc/BRIEF.md
# Periodic-Interrupt Real-Time Clock

This block is a compact time-of-day keeper that software reaches through two byte-wide I/O ports. A byte written to the index port chooses one internal register. The data port then reads or writes the chosen register. The block holds these time fields: seconds, minutes, hours, day of week, day of month, month and year. Four control slots sit beside them. They accept writes and do nothing with them.

A free-running prescaler gives one periodic interrupt pulse every `TICK_DIV` clock cycles. A counter of those pulses, modulo `TICKS_PER_SEC` (1024 by default), advances the seconds field once per full turn. The month and year fields are stored with a fixed bias: month is kept one below the written value, and year is kept 52 above it. The read path removes the bias, so a value written to either field reads back unchanged. After reset, however, the month reads as 1 and the year reads as 0xCC.

Top module: `rtc_periodic`

## Requirements
- R1: A write to I/O address 0x70 (the index port) latches the byte as the register index. A read of 0x70 returns the latched index.
- R2: A read (ioRdEn high) of address 0x70 or 0x71 puts its result on ioRdData after the next rising clock edge. With no such read, ioRdData keeps its value.
- R3: Data-port (0x71) writes to index 0x00 (seconds), 0x02 (minutes), 0x04 (hours), 0x06 (day of week) or 0x07 (day of month) store the byte as written, and a data-port read returns it unchanged.
- R4: Index 0x08 (month) stores the written byte minus 1 and reads back the stored value plus 1, modulo 256. A written month therefore reads back unchanged. After reset the month reads 0x01.
- R5: Index 0x09 (year) stores the written byte plus 52 and reads back the stored value minus 52, modulo 256. A written year therefore reads back unchanged. After reset the year reads 0xCC.
- R6: Indices 0x0A to 0x0D (control slots) read 0x00. Writes to them change no register, and they raise no error.
- R7: Any other index reads 0x00, and a write to it changes no register. A data-port read or write with such an index sets accessErr high for exactly the cycle after the access edge.
- R8: periodicIrq is a one-cycle pulse that repeats every TICK_DIV cycles. The first pulse is high TICK_DIV clock edges after reset is released.
- R9: On every TICKS_PER_SEC-th periodic pulse counted from reset, the seconds field advances by one. A value of 59 or more wraps to 0.
- R10: Reset clears every time field, the index, the pulse counter, the prescaler and ioRdData, and drives periodicIrq and accessErr low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | ADDR_W | I/O byte address (0x70 index port, 0x71 data port) |
| ioWrEn | input | 1 | Write strobe, one cycle per access |
| ioRdEn | input | 1 | Read strobe, one cycle per access |
| ioWrData | input | 8 | Write byte |
| ioRdData | output | 8 | Registered read byte |
| periodicIrq | output | 1 | Periodic interrupt pulse |
| accessErr | output | 1 | One-cycle flag for a data access to an unmapped index |

## Verification
The checks assume four things about the inputs:
- A read strobe and a write strobe never share a cycle.
- Each access lasts exactly one cycle.
- The reset pulse covers at least one clock edge.
- The strobes are low during reset.

The stimulus drives every strobe for a single cycle from the falling edge and drops it again on the next falling edge. It also drives the inputs idle throughout reset. The pulse-spacing and error-cause properties take their reference from reset release, and the bench starts the seconds test from a fresh reset so that the pulse count is known.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned DATA_W    = 8;
  localparam int unsigned SEC_LIMIT = 60;
  localparam logic [7:0]  MON_BIAS  = 8'd1;
  localparam logic [7:0]  YEAR_BIAS = 8'd52;

  typedef enum logic [3:0] {
    SEL_SEC, SEL_MIN, SEL_HR, SEL_DOW, SEL_DOM,
    SEL_MON, SEL_YR, SEL_CTL, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic    secStep;
    logic    wrEn;
    logic    rdEn;
    logic    rdIdx;
    regSel_e sel;
    logic [DATA_W-1:0] idx;
  } rtcStrobe_t;

  function automatic regSel_e selOf(input logic [DATA_W-1:0] idx);
    case (idx)
      8'h00:                      selOf = SEL_SEC;
      8'h02:                      selOf = SEL_MIN;
      8'h04:                      selOf = SEL_HR;
      8'h06:                      selOf = SEL_DOW;
      8'h07:                      selOf = SEL_DOM;
      8'h08:                      selOf = SEL_MON;
      8'h09:                      selOf = SEL_YR;
      8'h0A, 8'h0B, 8'h0C, 8'h0D: selOf = SEL_CTL;
      default:                    selOf = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned TICK_DIV      = 4,
  parameter int unsigned TICKS_PER_SEC = 1024,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 8'h70,
  parameter logic [ADDR_W-1:0] DATA_PORT = 8'h71
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [DATA_W-1:0] ioWrData,
  output rtcStrobe_t        strb,
  output logic              periodicIrq,
  output logic              accessErr
);

  localparam int unsigned PW  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned TCW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0]  PRE_LAST  = PW'(TICK_DIV - 1);
  localparam logic [TCW-1:0] TICK_LAST = TCW'(TICKS_PER_SEC - 1);

  logic [DATA_W-1:0] idxQ;
  logic [PW-1:0]     preQ;
  logic [TCW-1:0]    tickCntQ;
  logic              tick;
  logic              isIdx;
  logic              isData;
  regSel_e           sel;

  assign tick   = (preQ == PRE_LAST);
  assign isIdx  = (ioAddr == IDX_PORT);
  assign isData = (ioAddr == DATA_PORT);
  assign sel    = selOf(idxQ);

  always_comb begin
    strb.secStep = tick && (tickCntQ == TICK_LAST);
    strb.wrEn    = ioWrEn && isData;
    strb.rdEn    = ioRdEn && (isData || isIdx);
    strb.rdIdx   = isIdx;
    strb.sel     = sel;
    strb.idx     = idxQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ        <= '0;
      preQ        <= '0;
      tickCntQ    <= '0;
      periodicIrq <= 1'b0;
      accessErr   <= 1'b0;
    end else begin
      if (ioWrEn && isIdx) idxQ <= ioWrData;
      preQ        <= tick ? '0 : preQ + 1'b1;
      if (tick) tickCntQ <= (tickCntQ == TICK_LAST) ? '0 : tickCntQ + 1'b1;
      periodicIrq <= tick;
      accessErr   <= (ioWrEn || ioRdEn) && isData && (sel == SEL_NONE);
    end
  end

endmodule

// File: rtl/rtc_dp.sv
module rtc_dp
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] secQ, minQ, hrQ, dowQ, domQ, monQ, yrQ;
  logic [DATA_W-1:0] rdNext;
  logic              secWr;

  assign secWr = strb.wrEn && (strb.sel == SEL_SEC);

  always_comb begin
    if (strb.rdIdx) rdNext = strb.idx;
    else begin
      case (strb.sel)
        SEL_SEC: rdNext = secQ;
        SEL_MIN: rdNext = minQ;
        SEL_HR:  rdNext = hrQ;
        SEL_DOW: rdNext = dowQ;
        SEL_DOM: rdNext = domQ;
        SEL_MON: rdNext = monQ + MON_BIAS;
        SEL_YR:  rdNext = yrQ - YEAR_BIAS;
        default: rdNext = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ   <= '0;
      minQ   <= '0;
      hrQ    <= '0;
      dowQ   <= '0;
      domQ   <= '0;
      monQ   <= '0;
      yrQ    <= '0;
      rdData <= '0;
    end else begin
      if (secWr) secQ <= wrData;
      else if (strb.secStep)
        secQ <= (secQ >= DATA_W'(SEC_LIMIT - 1)) ? '0 : secQ + 1'b1;
      if (strb.wrEn) begin
        case (strb.sel)
          SEL_MIN: minQ <= wrData;
          SEL_HR:  hrQ  <= wrData;
          SEL_DOW: dowQ <= wrData;
          SEL_DOM: domQ <= wrData;
          SEL_MON: monQ <= wrData - MON_BIAS;
          SEL_YR:  yrQ  <= wrData + YEAR_BIAS;
          default: ;
        endcase
      end
      if (strb.rdEn) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 8,
  parameter int unsigned TICK_DIV      = 4,
  parameter int unsigned TICKS_PER_SEC = 1024,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 8'h70,
  parameter logic [ADDR_W-1:0] DATA_PORT = 8'h71
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  output logic              periodicIrq,
  output logic              accessErr
);

  rtcStrobe_t strb;

  rtc_ctrl #(
    .ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV), .TICKS_PER_SEC(TICKS_PER_SEC),
    .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
    .ioRdEn(ioRdEn), .ioWrData(ioWrData), .strb(strb),
    .periodicIrq(periodicIrq), .accessErr(accessErr)
  );

  rtc_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(ioWrData), .rdData(ioRdData)
  );

endmodule

// File: rtl/rtc_periodic_chk.sv
module rtc_periodic_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned TICK_DIV = 4,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 8'h70,
  parameter logic [ADDR_W-1:0] DATA_PORT = 8'h71
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWrEn,
  input logic              ioRdEn,
  input logic [7:0]        ioRdData,
  input logic              periodicIrq,
  input logic              accessErr
);

  logic [31:0] gapCnt;
  logic        seenIrq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= '0;
      seenIrq <= 1'b0;
    end else if (periodicIrq) begin
      gapCnt  <= '0;
      seenIrq <= 1'b1;
    end else begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // R8
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodicIrq && (TICK_DIV > 1)) |=> !periodicIrq);

  // R8
  irq_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodicIrq && seenIrq) |-> (gapCnt == TICK_DIV - 1));

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> $past((ioRdEn || ioWrEn) && (ioAddr == DATA_PORT)));

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ioRdEn && ((ioAddr == DATA_PORT) || (ioAddr == IDX_PORT))) |-> $stable(ioRdData));

  // R7
  err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accessErr && !((ioRdEn || ioWrEn) && (ioAddr == DATA_PORT))) |=> !accessErr);

endmodule

bind rtc_periodic rtc_periodic_chk #(
  .ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV), .IDX_PORT(IDX_PORT), .DATA_PORT(DATA_PORT)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
  .ioRdData(ioRdData), .periodicIrq(periodicIrq), .accessErr(accessErr)
);

// File: tb/rtc_periodic_tb.sv
module rtc_periodic_tb;

  localparam int unsigned TICK_DIV      = 4;
  localparam int unsigned TICKS_PER_SEC = 1024;
  localparam logic [7:0]  IDXP = 8'h70;
  localparam logic [7:0]  DATP = 8'h71;
  localparam int NVEC = 13;

  // {index, write byte, expected read, expected error}
  localparam logic [24:0] VEC [NVEC] = '{
    {8'h00, 8'h2A, 8'h2A, 1'b0},  // R3 seconds
    {8'h02, 8'h3B, 8'h3B, 1'b0},  // R3 minutes
    {8'h04, 8'h17, 8'h17, 1'b0},  // R3 hours
    {8'h06, 8'h05, 8'h05, 1'b0},  // R3 day of week
    {8'h07, 8'h1F, 8'h1F, 1'b0},  // R3 day of month
    {8'h08, 8'h0C, 8'h0C, 1'b0},  // R4 month
    {8'h08, 8'h00, 8'h00, 1'b0},  // R4 month zero wraps in storage
    {8'h09, 8'h63, 8'h63, 1'b0},  // R5 year
    {8'h09, 8'h00, 8'h00, 1'b0},  // R5 year zero
    {8'h0A, 8'h55, 8'h00, 1'b0},  // R6 control slot
    {8'h0D, 8'hFF, 8'h00, 1'b0},  // R6 control slot
    {8'h01, 8'h77, 8'h00, 1'b1},  // R7 unmapped
    {8'h3F, 8'h12, 8'h00, 1'b1}   // R7 unmapped
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] ioAddr = '0;
  logic       ioWrEn = 1'b0;
  logic       ioRdEn = 1'b0;
  logic [7:0] ioWrData = '0;
  logic [7:0] ioRdData;
  logic       periodicIrq;
  logic       accessErr;

  int checks = 0;
  int failures = 0;
  int irqSeen = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  rtc_periodic #(.TICK_DIV(TICK_DIV), .TICKS_PER_SEC(TICKS_PER_SEC)) u_dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .periodicIrq(periodicIrq),
    .accessErr(accessErr)
  );

  always @(posedge clk) begin
    if (!rstN) irqSeen <= 0;
    else if (periodicIrq) irqSeen <= irqSeen + 1;
  end

  function automatic string tagOf(input logic [7:0] idx);
    case (idx)
      8'h00, 8'h02, 8'h04, 8'h06, 8'h07: tagOf = "R3";
      8'h08: tagOf = "R4";
      8'h09: tagOf = "R5";
      8'h0A, 8'h0B, 8'h0C, 8'h0D: tagOf = "R6";
      default: tagOf = "R7";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    ioAddr = a; ioRdEn = 1'b1;
    @(negedge clk);
    ioRdEn = 1'b0;
    d = ioRdData;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitIrq(input int n);
    while (irqSeen < n) @(negedge clk);
  endtask

  initial begin
    int cyc;
    #1600000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    @(negedge clk);
    doReset();
    // R10 reset state at the ports
    check("R10 rdData", ioRdData, 0);
    check("R10 irq", periodicIrq, 0);
    check("R10 err", accessErr, 0);
    rd(IDXP, rv); check("R10 index", rv, 0);
    rd(DATP, rv); check("R10 seconds", rv, 0);
    wr(IDXP, 8'h08); rd(DATP, rv); check("R4 reset month", rv, 8'h01);
    wr(IDXP, 8'h09); rd(DATP, rv); check("R5 reset year", rv, 8'hCC);
    rd(IDXP, rv); check("R1 index readback", rv, 8'h09);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] vi, vw, ve;
      logic verr;
      {vi, vw, ve, verr} = VEC[i];
      wr(IDXP, vi);
      check({tagOf(vi), " idx write err"}, accessErr, 0);
      wr(DATP, vw);
      check({tagOf(vi), " write err"}, accessErr, verr);
      rd(DATP, rv);
      check({tagOf(vi), " read"}, rv, ve);
      check({tagOf(vi), " read err"}, accessErr, verr);
    end

    // R6 R7 ignored writes left other fields alone
    wr(IDXP, 8'h00); rd(DATP, rv); check("R7 seconds intact", rv, 8'h2A);
    wr(IDXP, 8'h02); rd(DATP, rv); check("R6 minutes intact", rv, 8'h3B);
    wr(IDXP, 8'h07); rd(DATP, rv); check("R7 day intact", rv, 8'h1F);
    // R7 error pulse lasts one cycle
    @(negedge clk); check("R7 err low after", accessErr, 0);
    // R2 hold without read, and non-port read leaves data
    wr(IDXP, 8'h04); rd(DATP, rv);
    repeat (3) @(negedge clk);
    check("R2 hold", ioRdData, 8'h17);
    rd(8'h55, rv); check("R2 other address", rv, 8'h17);

    // R8 pulse timing from reset
    doReset();
    cyc = 0;
    while (!periodicIrq && cyc < 100) begin @(negedge clk); cyc++; end
    check("R8 first pulse", cyc, TICK_DIV);
    @(negedge clk); check("R8 pulse width", periodicIrq, 0);
    cyc = 1;
    while (!periodicIrq && cyc < 100) begin @(negedge clk); cyc++; end
    check("R8 period", cyc, TICK_DIV);

    // R9 seconds advance from a fresh reset
    doReset();
    wr(IDXP, 8'h00); wr(DATP, 8'd59);
    waitIrq(TICKS_PER_SEC - 1);
    rd(DATP, rv); check("R9 before wrap", rv, 59);
    waitIrq(TICKS_PER_SEC);
    rd(DATP, rv); check("R9 wrap to zero", rv, 0);
    waitIrq(2 * TICKS_PER_SEC);
    rd(DATP, rv); check("R9 next second", rv, 1);
    wr(DATP, 8'd200);
    waitIrq(3 * TICKS_PER_SEC);
    rd(DATP, rv); check("R9 above limit wraps", rv, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule